// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block lets an outside master borrow a memory interface bus through an active-low request and acknowledge pair. After it sees the request, it stops the local transaction engine from starting new work. It waits for any transfer still in progress to end, then floats the bus outputs and lowers the acknowledge. When the request goes away, it drives the bus again, lets the engine run, and then raises the acknowledge.

A configuration input chooses what the bus clock output does while the bus is held. It can keep toggling, or it can float and return together with the bus. An inhibit input blocks any grant for as long as it is set. The request pin is passed through a two-stage synchronizer. All delays are counted in interface clock edges. `FLOAT_CYC` sets how many cycles the bus is still driven once a grant is allowed. `REDRIVE_CYC` sets how many cycles it stays floated after the request is withdrawn. Edge numbers below count rising edges from the first edge that samples a new level on `hold_n_i`, with `inhibit_i` low.

Top module: `bus_hold_ctrl`

## Requirements
- R1: During and after reset, `holda_n_o` is 1, `bus_oe_o` is 1, `clkout_oe_o` is 1 and `start_block_o` is 0.
- R2: When `hold_n_i` goes low with `busy_i` low, `start_block_o` rises after edge 3. `bus_oe_o` falls after edge FLOAT_CYC+3 (4 by default), and `holda_n_o` falls in the same cycle. `start_block_o` stays 1 whenever the bus is floated.
- R3: If `busy_i` is high when the request is seen, no grant is made. Once `busy_i` is first sampled low at edge e, the grant follows after edge e+FLOAT_CYC. `holda_n_o` is never low while `busy_i` is high.
- R4: While `inhibit_i` is 1, `holda_n_o` stays 1 and `bus_oe_o` stays 1. Once `inhibit_i` is first sampled 0 at edge e, the grant follows after edge e+FLOAT_CYC. A grant never falls in the cycle right after inhibit was sampled 1.
- R5: When `hold_n_i` rises during a grant, `bus_oe_o` returns to 1 and `start_block_o` to 0 after edge REDRIVE_CYC+3 (4 by default). `holda_n_o` returns to 1 one edge later.
- R6: With `clk_float_i` = 0, `clkout_oe_o` stays 1 throughout a hold. With `clk_float_i` = 1, `clkout_oe_o` equals `bus_oe_o`.
- R7: If `hold_n_i` rises again before a grant, no acknowledge is given. `start_block_o` falls after edge 3 of the withdrawal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_n_i | input | 1 | Bus request from the outside master, active low, asynchronous |
| busy_i | input | 1 | High while the transaction engine has a transfer in flight |
| inhibit_i | input | 1 | Blocks hold grants while 1 |
| clk_float_i | input | 1 | 1: bus clock output floats during hold; 0: it keeps running |
| holda_n_o | output | 1 | Hold acknowledge, active low |
| bus_oe_o | output | 1 | Output enable of the bus pins |
| clkout_oe_o | output | 1 | Output enable of the bus clock pin |
| start_block_o | output | 1 | Tells the transaction engine not to start new transfers |

## Verification
The assertions assume the transaction engine obeys `start_block_o`, so `busy_i` never rises while it is set. They also assume the outside master keeps `hold_n_i` low until well after the acknowledge falls. The stimulus lowers `busy_i` only before a grant and never raises it again during a hold. It changes `hold_n_i` only at falling clock edges, and it keeps each request until the acknowledge is seen plus two more cycles. A withdrawn request, tested on purpose, is removed only while the block is still draining, before any grant.

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
  parameter int FLOAT_CYC   = 1,
  parameter int REDRIVE_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_n_i,
  input  logic busy_i,
  input  logic inhibit_i,
  input  logic clk_float_i,
  output logic holda_n_o,
  output logic bus_oe_o,
  output logic clkout_oe_o,
  output logic start_block_o
);
  localparam int CMAX = (FLOAT_CYC > REDRIVE_CYC) ? FLOAT_CYC : REDRIVE_CYC;
  localparam int CW   = (CMAX > 1) ? $clog2(CMAX) : 1;

  typedef enum logic [2:0] {
    S_OWN, S_DRAIN, S_FLOAT_WAIT, S_GRANTED, S_REDRIVE_WAIT, S_RELEASE
  } st_t;

  st_t           st, st_nx;
  logic [1:0]    sync;
  logic [CW-1:0] cnt, cnt_nx;
  logic          req, can_go;

  assign req    = ~sync[1];
  assign can_go = ~busy_i & ~inhibit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      st   <= S_OWN;
      cnt  <= '0;
    end else begin
      sync <= {sync[0], hold_n_i};
      st   <= st_nx;
      cnt  <= cnt_nx;
    end
  end

  always_comb begin
    st_nx  = st;
    cnt_nx = '0;
    case (st)
      S_OWN:
        if (req) st_nx = can_go ? S_FLOAT_WAIT : S_DRAIN;
      S_DRAIN:
        if (!req)        st_nx = S_OWN;
        else if (can_go) st_nx = S_FLOAT_WAIT;
      S_FLOAT_WAIT:
        if (!req)         st_nx = S_OWN;
        else if (!can_go) st_nx = S_DRAIN;
        else if (cnt == CW'(FLOAT_CYC - 1)) st_nx = S_GRANTED;
        else cnt_nx = cnt + 1'b1;
      S_GRANTED:
        if (!req) st_nx = S_REDRIVE_WAIT;
      S_REDRIVE_WAIT:
        if (cnt == CW'(REDRIVE_CYC - 1)) st_nx = S_RELEASE;
        else cnt_nx = cnt + 1'b1;
      S_RELEASE:
        st_nx = S_OWN;
      default:
        st_nx = S_OWN;
    endcase
  end

  assign holda_n_o     = ~(st == S_GRANTED || st == S_REDRIVE_WAIT || st == S_RELEASE);
  assign bus_oe_o      = ~(st == S_GRANTED || st == S_REDRIVE_WAIT);
  assign start_block_o = (st == S_DRAIN) || (st == S_FLOAT_WAIT) ||
                         (st == S_GRANTED) || (st == S_REDRIVE_WAIT);
  assign clkout_oe_o   = bus_oe_o | ~clk_float_i;

endmodule

// File: rtl/bus_hold_ctrl_chk.sv
module bus_hold_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_n_i,
  input logic busy_i,
  input logic inhibit_i,
  input logic clk_float_i,
  input logic holda_n_o,
  input logic bus_oe_o,
  input logic clkout_oe_o,
  input logic start_block_o
);
  a_r2_float_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holda_n_o) |-> !bus_oe_o);
  a_r2_block_while_floated: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> start_block_o);
  a_r2_min_float_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe_o) |-> !$past(hold_n_i, 2));
  a_r3_no_grant_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !holda_n_o |-> !busy_i);
  a_r4_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holda_n_o) |-> !$past(inhibit_i));
  a_r5_drive_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holda_n_o) |-> bus_oe_o && $past(bus_oe_o));
  a_r6_clock_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_float_i |-> clkout_oe_o);
endmodule

bind bus_hold_ctrl bus_hold_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold_n_i(hold_n_i), .busy_i(busy_i),
  .inhibit_i(inhibit_i), .clk_float_i(clk_float_i), .holda_n_o(holda_n_o),
  .bus_oe_o(bus_oe_o), .clkout_oe_o(clkout_oe_o), .start_block_o(start_block_o)
);

// File: tb/sim_bus_hold_ctrl.sv
module sim_bus_hold_ctrl;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  localparam int VB[NV] = '{0, 1, 2, 3, 6, 10};
  localparam bit VC[NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic hold_n = 1'b1, busy = 1'b0, inhibit = 1'b0, cflt = 1'b0;
  logic holda_n, bus_oe, clk_oe, blk;
  int n_chk = 0, n_bad = 0, n;
  bit done = 1'b0;

  bus_hold_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hold_n_i(hold_n), .busy_i(busy),
    .inhibit_i(inhibit), .clk_float_i(cflt), .holda_n_o(holda_n),
    .bus_oe_o(bus_oe), .clkout_oe_o(clk_oe), .start_block_o(blk)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); n++; @(negedge clk);
  endtask

  task automatic release_hold();
    hold_n = 1'b1; n = 0;
    while (!bus_oe && n < 40) tick();
    chk("R5 redrive edge", n, 4);
    chk("R5 ack low at redrive", holda_n, 0);
    chk("R5 block dropped", blk, 0);
    tick();
    chk("R5 ack released", holda_n, 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ack", holda_n, 1); chk("R1 bus oe", bus_oe, 1);
    chk("R1 clk oe", clk_oe, 1); chk("R1 block", blk, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ack after reset", holda_n, 1);

    for (int v = 0; v < NV; v++) begin
      int ex;
      ex = (VB[v] + 2 > 4) ? VB[v] + 2 : 4;
      cflt = VC[v]; busy = (VB[v] > 0); hold_n = 1'b0; n = 0;
      while (holda_n && n < 50) begin
        tick();
        if (n == VB[v]) busy = 1'b0;
        if (n == 3) chk("R2 block raised", blk, 1);
        if (holda_n) chk("R3 bus kept before grant", bus_oe, 1);
      end
      chk(VB[v] > 2 ? "R3 drained grant edge" : "R2 grant edge", n, ex);
      chk("R2 bus floated", bus_oe, 0);
      chk("R6 clock oe in hold", clk_oe, !VC[v]);
      tick(); tick();
      chk("R2 still blocked", blk, 1);
      release_hold();
      chk("R6 clock oe after", clk_oe, 1);
      tick();
    end

    inhibit = 1'b1; cflt = 1'b1; hold_n = 1'b0; n = 0;
    repeat (20) begin
      tick();
      chk("R4 ack withheld", holda_n, 1);
      chk("R4 bus kept", bus_oe, 1);
    end
    chk("R4 block while inhibited", blk, 1);
    inhibit = 1'b0; n = 0;
    while (holda_n && n < 20) tick();
    chk("R4 grant after inhibit clear", n, 2);
    chk("R6 clock floated", clk_oe, 0);
    tick(); tick();
    release_hold();

    busy = 1'b1; hold_n = 1'b0; n = 0;
    repeat (5) tick();
    chk("R7 block during drain", blk, 1);
    hold_n = 1'b1; n = 0;
    repeat (2) tick();
    chk("R7 block held edge 2", blk, 1);
    tick();
    chk("R7 block dropped edge 3", blk, 0);
    chk("R7 no ack", holda_n, 1);
    busy = 1'b0;
    repeat (4) tick();
    chk("R7 stays idle", holda_n, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule